// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the control sequencer of a multichannel analog-to-digital converter peripheral. Software sets a channel-enable mask spread over two 16-bit words, picks single or continuous scanning and raises a run bit. The sequencer then visits every enabled channel from the lowest number to the highest. For each one it sends a one-cycle convert request to the converter and waits for the converter's done pulse. It passes the returned 12-bit sample, tagged with its channel number, on to the result storage.

Each pass is framed by a fixed start phase and a fixed end phase. The lengths of both phases are parameters. A one-cycle scan-complete interrupt marks the end of every pass, and a transfer engine may use it as a trigger as well. In single mode the sequencer goes idle after one pass. In continuous mode it runs the next pass until software clears the run bit, and clearing that bit halts it in the following cycle.

Top module: `adc_scan_seq`

## Requirements
- R1: Channel n is converted only when bit n of the 32-bit mask {en_hi, en_lo} is 1. Channels 0 to 15 come from en_lo and channels 16 to 31 from en_hi; a channel whose bit is 0 is never requested.
- R2: Within one pass each enabled channel is converted exactly once, in ascending order. res_valid pulses in the cycle after conv_done and carries the channel number and the sample that conv_data held when conv_done was high.
- R3: In single mode (cont_mode = 0) a pass ends with one interrupt and the block returns to idle. Holding run_en high does not start another pass; only a new 0-to-1 change of run_en does.
- R4: In continuous mode (cont_mode = 1) the sequencer goes back to the lowest enabled channel after the highest one. It raises one interrupt per pass, and consecutive interrupts are exactly START_DLY + N*(LAT+1) + END_DLY cycles apart.
- R5: Scan timing: START_DLY cycles of start phase, then for each of the N enabled channels one request cycle plus the wait until conv_done, then END_DLY cycles of end phase. Let the converter raise conv_done LAT cycles after it samples the request. scan_irq is then high in the cycle that follows the (START_DLY + N*(LAT+1) + END_DLY + 1)-th rising edge, counting from the edge that samples the rise of run_en.
- R6: scan_irq is high for exactly one cycle per pass.
- R7: When run_en is sampled low, busy, conv_req, res_valid and scan_irq are all low from the next cycle on. A conv_done that arrives later is ignored.
- R8: A rise of run_en while the mask is all zeros leaves the block idle: busy stays low, and no request and no interrupt are issued.
- R9: The mask and the mode are captured when the scan starts. Changes to en_lo, en_hi or cont_mode during a scan do not alter the channel sequence.
- R10: conv_req is high for one cycle per channel, and only one conversion is outstanding at a time.
- R11: After reset busy, conv_req, res_valid and scan_irq are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run bit; a rise starts a scan, and low stops it |
| cont_mode | input | 1 | 0 = single pass, 1 = continuous passes |
| en_lo | input | 16 | Enable bits for channels 0 to 15 |
| en_hi | input | 16 | Enable bits for channels 16 to 31 |
| conv_req | output | 1 | One-cycle convert request |
| conv_ch | output | 5 | Channel being converted |
| conv_done | input | 1 | Converter finished the requested sample |
| conv_data | input | 12 | Sample from the converter, valid with conv_done |
| res_valid | output | 1 | Result strobe to result storage |
| res_ch | output | 5 | Channel number of the result |
| res_data | output | 12 | Converted sample |
| scan_irq | output | 1 | One-cycle scan-complete pulse |
| busy | output | 1 | A scan is in progress |

## Verification
The in-line assertions check on every cycle the properties that hold locally in time. Each convert request lasts one cycle and targets an enabled channel. Results follow a done pulse and rise in channel order within a pass. The interrupt lasts one cycle, and the block falls quiet in the cycle after the run bit is seen low. Other properties only show across a whole scenario, and the bench checks those. They are the exact cycle count from start to interrupt, the period between passes in continuous mode, the number of results per pass, the sample values, the lack of a restart while the run bit stays high in single mode, the idle response to an empty mask, and the way the captured mask ignores edits made mid-scan.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_LEAD  = 3'd1,
      SQ_ISSUE = 3'd2,
      SQ_HOLD  = 3'd3,
      SQ_TAIL  = 3'd4
   } seq_state_e;

endpackage

// File: rtl/adc_next_ch.sv
// Finds the lowest enabled channel, either from the bottom of the mask or
// strictly above a given channel.
module adc_next_ch #(
   parameter int NUM_CH = 32,
   parameter int CH_W   = 5
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [CH_W-1:0]   above_ch,
   input  logic              from_bottom,
   output logic              found,
   output logic [CH_W-1:0]   next_ch
);

   always_comb begin
      found   = 1'b0;
      next_ch = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (mask[i] && (from_bottom || (i > int'(above_ch)))) begin
            found   = 1'b1;
            next_ch = CH_W'(i);
         end
      end
   end

endmodule

// File: rtl/adc_phase_timer.sv
// Down-counter for the lead-in and tail phases; last is high on the final cycle.
module adc_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
   parameter int NUM_CH    = 32,
   parameter int WORD_W    = 16,
   parameter int SAMPLE_W  = 12,
   parameter int START_DLY = 4,
   parameter int END_DLY   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        run_en,
   input  logic                        cont_mode,
   input  logic [WORD_W-1:0]           en_lo,
   input  logic [WORD_W-1:0]           en_hi,
   output logic                        conv_req,
   output logic [$clog2(NUM_CH)-1:0]   conv_ch,
   input  logic                        conv_done,
   input  logic [SAMPLE_W-1:0]         conv_data,
   output logic                        res_valid,
   output logic [$clog2(NUM_CH)-1:0]   res_ch,
   output logic [SAMPLE_W-1:0]         res_data,
   output logic                        scan_irq,
   output logic                        busy
);
   import adc_scan_pkg::*;

   localparam int CH_W    = $clog2(NUM_CH);
   localparam int MAX_DLY = (START_DLY > END_DLY) ? START_DLY : END_DLY;
   localparam int DLY_W   = $clog2(MAX_DLY + 1);

   generate
      if (START_DLY < 1 || END_DLY < 1) begin : g_bad_dly
         $error("adc_scan_seq: phase delays must be at least one cycle");
      end
      if (NUM_CH <= WORD_W || NUM_CH > 2 * WORD_W) begin : g_bad_ch
         $error("adc_scan_seq: NUM_CH must span both enable words");
      end
   endgenerate

   // Mask assembly from the two enable words
   logic [2*WORD_W-1:0] en_all;
   logic [NUM_CH-1:0]   mask_in;
   assign en_all  = {en_hi, en_lo};
   assign mask_in = en_all[NUM_CH-1:0];

   seq_state_e        state_q, state_n;
   logic              run_q;
   logic              start_evt;
   logic [NUM_CH-1:0] mask_q;
   logic              mode_q;
   logic [CH_W-1:0]   cur_ch_q;
   logic              tmr_load;
   logic [DLY_W-1:0]  tmr_val;
   logic              tmr_last;
   logic              nxt_found;
   logic [CH_W-1:0]   nxt_ch;

   assign start_evt = run_en & ~run_q;

   adc_next_ch #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
      .mask        (mask_q),
      .above_ch    (cur_ch_q),
      .from_bottom (state_q == SQ_LEAD),
      .found       (nxt_found),
      .next_ch     (nxt_ch)
   );

   adc_phase_timer #(.CNT_W(DLY_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   always_comb begin
      state_n  = state_q;
      tmr_load = 1'b0;
      tmr_val  = DLY_W'(START_DLY - 1);
      case (state_q)
         SQ_IDLE: begin
            if (start_evt && (|mask_in)) begin
               state_n  = SQ_LEAD;
               tmr_load = 1'b1;
            end
         end
         SQ_LEAD: begin
            if (tmr_last) state_n = SQ_ISSUE;
         end
         SQ_ISSUE: state_n = SQ_HOLD;
         SQ_HOLD: begin
            if (conv_done) begin
               if (nxt_found) begin
                  state_n = SQ_ISSUE;
               end else begin
                  state_n  = SQ_TAIL;
                  tmr_load = 1'b1;
                  tmr_val  = DLY_W'(END_DLY - 1);
               end
            end
         end
         SQ_TAIL: begin
            if (tmr_last) begin
               if (mode_q) begin
                  state_n  = SQ_LEAD;
                  tmr_load = 1'b1;
               end else begin
                  state_n = SQ_IDLE;
               end
            end
         end
         default: state_n = SQ_IDLE;
      endcase
      if (state_q != SQ_IDLE && !run_en) begin
         state_n  = SQ_IDLE;
         tmr_load = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         run_q     <= 1'b0;
         mask_q    <= '0;
         mode_q    <= 1'b0;
         cur_ch_q  <= '0;
         res_valid <= 1'b0;
         res_ch    <= '0;
         res_data  <= '0;
         scan_irq  <= 1'b0;
      end else begin
         state_q   <= state_n;
         run_q     <= run_en;
         res_valid <= 1'b0;
         scan_irq  <= 1'b0;
         if (state_q == SQ_IDLE && start_evt) begin
            mask_q <= mask_in;
            mode_q <= cont_mode;
         end
         if ((state_q == SQ_LEAD && tmr_last) ||
             (state_q == SQ_HOLD && conv_done && nxt_found))
            cur_ch_q <= nxt_ch;
         if (state_q == SQ_HOLD && conv_done && run_en) begin
            res_valid <= 1'b1;
            res_ch    <= cur_ch_q;
            res_data  <= conv_data;
         end
         if (state_q == SQ_TAIL && tmr_last && run_en)
            scan_irq <= 1'b1;
      end
   end

   assign conv_req = (state_q == SQ_ISSUE);
   assign conv_ch  = cur_ch_q;
   assign busy     = (state_q != SQ_IDLE);

   // ---------------- assertions ----------------
   logic            chk_have_q;
   logic [CH_W-1:0] chk_last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_have_q <= 1'b0;
         chk_last_q <= '0;
      end else if (scan_irq || state_q == SQ_IDLE) begin
         chk_have_q <= 1'b0;
      end else if (res_valid) begin
         chk_have_q <= 1'b1;
         chk_last_q <= res_ch;
      end
   end

   // R10
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);

   // R1
   req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> mask_q[conv_ch]);

   // R2
   res_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(conv_done));

   // R2
   ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && chk_have_q) |-> (res_ch > chk_last_q));

   // R6
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_irq |=> !scan_irq);

   // R7
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!busy && !conv_req && !res_valid && !scan_irq));

endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;

   localparam int D   = 4;
   localparam int ED  = 3;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        cont_mode = 1'b0;
   logic [15:0] en_lo = '0;
   logic [15:0] en_hi = '0;
   logic        conv_req;
   logic [4:0]  conv_ch;
   logic        conv_done;
   logic [11:0] conv_data;
   logic        res_valid;
   logic [4:0]  res_ch;
   logic [11:0] res_data;
   logic        scan_irq;
   logic        busy;

   int checks = 0;
   int failures = 0;
   logic [11:0] salt = 12'h000;

   always #2 clk = ~clk;

   adc_scan_seq uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .cont_mode(cont_mode),
      .en_lo(en_lo), .en_hi(en_hi), .conv_req(conv_req), .conv_ch(conv_ch),
      .conv_done(conv_done), .conv_data(conv_data), .res_valid(res_valid),
      .res_ch(res_ch), .res_data(res_data), .scan_irq(scan_irq), .busy(busy)
   );

   function automatic logic [11:0] sample_of(int ch, logic [11:0] s);
      return 12'(ch * 613) ^ s;
   endfunction

   // converter stub: done LAT cycles after it samples the request
   logic [3:0] lat_cnt;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt   <= '0;
         conv_data <= '0;
      end else if (conv_req) begin
         lat_cnt   <= 4'(LAT);
         conv_data <= sample_of(int'(conv_ch), salt);
      end else if (lat_cnt != 0) begin
         lat_cnt <= lat_cnt - 1'b1;
      end
   end
   assign conv_done = (lat_cnt == 4'd1);

   function automatic int popc(logic [31:0] m);
      int n = 0;
      for (int i = 0; i < 32; i++) n += int'(m[i]);
      return n;
   endfunction

   function automatic int next_en(logic [31:0] m, int prev);
      for (int i = prev + 1; i < 32; i++) if (m[i]) return i;
      return -1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // quiet window: nothing may be issued
   task automatic expect_quiet(input int cycles, input string req);
      int bad = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (busy || conv_req || res_valid || scan_irq) bad++;
      end
      check(bad == 0, req, bad, 0);
   endtask

   // one scan scenario; scramble edits the enable words mid-scan (R9)
   task automatic run_scan(input logic [31:0] m, input bit cont, input int passes,
                           input bit scramble);
      int n = popc(m);
      int edges = 0;
      int pass = 0;
      int nres = 0;
      int expc;
      int guard = 0;
      @(negedge clk);
      en_lo = m[15:0];
      en_hi = m[31:16];
      cont_mode = cont;
      salt = 12'($urandom);
      run_en = 1'b1;
      expc = next_en(m, -1);
      while (pass < passes && guard < 4000) begin
         @(posedge clk);
         edges++;
         guard++;
         @(negedge clk);
         if (res_valid) begin
            // R1 R2 R9
            check(int'(res_ch) == expc, "R2 channel order", int'(res_ch), expc);
            check(res_data == sample_of(expc, salt), "R2 sample", int'(res_data),
                  int'(sample_of(expc, salt)));
            expc = next_en(m, expc);
            nres++;
            if (scramble) begin
               en_lo = 16'($urandom);
               en_hi = 16'($urandom);
               cont_mode = ~cont;
            end
         end
         if (scan_irq) begin
            check(nres == n, "R2 results per pass", nres, n);
            if (pass == 0)
               check(edges == D + n * (LAT + 1) + ED + 1, "R5 scan time", edges,
                     D + n * (LAT + 1) + ED + 1);
            else
               check(edges == D + n * (LAT + 1) + ED, "R4 pass period", edges,
                     D + n * (LAT + 1) + ED);
            @(posedge clk);
            @(negedge clk);
            check(scan_irq == 1'b0, "R6 irq width", int'(scan_irq), 0);
            edges = 1;
            pass++;
            nres = 0;
            expc = next_en(m, -1);
            if (res_valid) begin
               check(int'(res_ch) == expc, "R4 wrap", int'(res_ch), expc);
               expc = next_en(m, expc);
               nres++;
            end
         end
      end
      check(guard < 4000, "R5 scan finished", guard, 4000);
      if (!cont) begin
         // R3: run held high, no restart
         expect_quiet(30, "R3 no restart while run high");
      end
      @(negedge clk);
      run_en = 1'b0;
      expect_quiet(LAT + 6, "R7 quiet after stop");
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R11 reset state
      check(!busy && !conv_req && !res_valid && !scan_irq, "R11 reset outputs",
            int'({busy, conv_req, res_valid, scan_irq}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8 empty mask
      en_lo = '0; en_hi = '0; run_en = 1'b1;
      expect_quiet(20, "R8 empty mask stays idle");
      run_en = 1'b0;
      repeat (2) @(negedge clk);

      // directed corners
      run_scan(32'h0000_0001, 1'b0, 1, 1'b0);   // lowest only
      run_scan(32'h8000_0000, 1'b0, 1, 1'b0);   // highest only (R1 high word)
      run_scan(32'hFFFF_FFFF, 1'b0, 1, 1'b0);   // all channels
      run_scan(32'h0001_8000, 1'b1, 3, 1'b0);   // word boundary, continuous R4
      run_scan(32'h0A50_00C3, 1'b0, 1, 1'b1);   // R9 mid-scan edits ignored

      // R7 stop in the middle of a scan
      @(negedge clk);
      en_lo = 16'hFFFF; en_hi = 16'hFFFF; cont_mode = 1'b0; run_en = 1'b1;
      begin
         int seen = 0;
         int guard = 0;
         while (seen < 3 && guard < 1000) begin
            @(negedge clk);
            guard++;
            if (res_valid) seen++;
         end
         check(seen == 3, "R7 partial scan ran", seen, 3);
      end
      run_en = 1'b0;
      expect_quiet(LAT + 8, "R7 stop mid-scan");

      // constrained random
      for (int t = 0; t < 14; t++) begin
         logic [31:0] m = $urandom;
         bit c = 1'($urandom);
         if ($urandom % 3 == 0) m = m & $urandom & $urandom;
         if (m == 0) m = 32'h0000_0100;
         run_scan(m, c, c ? 2 : 1, 1'($urandom));
      end

      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

endmodule